// File: doc/BRIEF.md
# Selector-Row Parallel Multiplier

This block multiplies two N-bit operands and returns the full 2N-bit product as one word, entirely in combinational logic. It stores nothing and has no clock. Each bit position j contributes one row. The row looks at bit j of both operands and chooses one of four candidate values: zero, the low j bits of the first operand, the low j bits of the second operand, or the low j+1 bits of the operand sum. The operand sum is formed once by a single ripple adder, and every row takes its slice from that adder. The rows are then added with weight 2^j. The diagonal bits x_j·y_j are added with weight 4^j.

An elaboration parameter picks unsigned or two's complement operation. In two's complement mode only the top row is subtracted; every other row is still added. The subtraction uses the inverted top-row term plus a carry-in of one. A second parameter sets where the top bit of each sum slice comes from: the adder's carry into position j, or sum bit j. The two sources give the same product. A designer can drop the block into a datapath wherever a single-cycle product is wanted. Any registering belongs to the surrounding logic.

Top module: `mux_array_mult`

## Requirements
- R1: With SIGNED_MODE = 0, `product` equals the unsigned product of `op_x` and `op_y` for every operand pair.
- R2: With SIGNED_MODE = 1, `product` equals the two's complement product of `op_x` and `op_y`, sign-extended to 2N bits, for every operand pair.
- R3: With SIGNED_MODE = 1 and N = 8, operands 0xED (-19) and 0x16 (+22) give 0xFE5E (-418).
- R4: For j ≥ 1, row j's term depends on bit j of `op_x` (xj) and bit j of `op_y` (yj). The pair xj=0, yj=0 gives 0. The pair xj=1, yj=0 gives op_y[j-1:0]. The pair xj=0, yj=1 gives op_x[j-1:0]. The pair xj=1, yj=1 gives op_x[j-1:0] + op_y[j-1:0] as a (j+1)-bit value. For N = 8, unsigned operands 0x80 and 0x7F give 0x3F80, which isolates the xj=1, yj=0 choice in the top row.
- R5: Exchanging `op_x` and `op_y` leaves `product` unchanged.
- R6: Wherever bit j of both operands is 1, the shared adder's sum bit j equals its carry into bit j. As a result, MSB_FROM_SUM = 0 and MSB_FROM_SUM = 1 give identical products for every operand pair.
- R7: If either operand is zero, `product` is zero.
- R8: `product` follows an operand change within the same clock period, with no register latency.
- R9: At N = 8 the extremes are exact: unsigned 0xFF × 0xFF gives 0xFE01, signed 0x80 × 0x80 gives 0x4000, and signed 0x80 × 0x7F gives 0xC080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | N | First operand (unsigned or two's complement, per SIGNED_MODE) |
| op_y | input | N | Second operand (same encoding as op_x) |
| product | output | 2N | Full product as one word |

## Verification
The block has no state, so a wrong row selection, a bad slice of the shared sum, or a sign error on the top row shows up on `product` as soon as the operands settle. It appears for every operand pair that exercises the faulty row. The exhaustive sweep therefore exposes any such fault in the first cycle that applies a pair with the offending bit pattern. The swapped-operand instance and the alternate-slice instance catch faults that break symmetry or the equality of sum bit and carry. A stuck or inverted top-row subtraction corrupts every signed pair whose operands both have a nonzero top-row term.

// File: rtl/mxm_pkg.sv
package mxm_pkg;

    // Row choice, keyed by {x_j, y_j}
    typedef enum logic [1:0] {
        PICK_ZERO = 2'b00,
        PICK_XLOW = 2'b01,
        PICK_YLOW = 2'b10,
        PICK_SUM  = 2'b11
    } row_pick_e;

    function automatic row_pick_e decode_pick(input logic xb, input logic yb);
        return row_pick_e'({xb, yb});
    endfunction

endpackage

// File: rtl/mxm_operand_adder.sv
module mxm_operand_adder #(
    parameter int N = 8
) (
    input  logic [N-1:0] add_a,
    input  logic [N-1:0] add_b,
    output logic [N-1:0] sum_bits,
    output logic [N-1:0] carry_bits
);
    // carry_bits[i] is the carry entering position i
    logic [N:0] chain_d;

    always_comb begin
        chain_d[0] = 1'b0;
        for (int i = 0; i < N; i++) begin
            sum_bits[i]   = add_a[i] ^ add_b[i] ^ chain_d[i];
            chain_d[i+1]  = (add_a[i] & add_b[i]) | (chain_d[i] & (add_a[i] ^ add_b[i]));
            carry_bits[i] = chain_d[i];
        end
    end

endmodule

// File: rtl/mxm_row_select.sv
module mxm_row_select #(
    parameter int J = 1
) (
    input  logic         xb,
    input  logic         yb,
    input  logic [J-1:0] low_x,
    input  logic [J-1:0] low_y,
    input  logic [J-1:0] sum_low,
    input  logic         sum_msb,
    output logic [J:0]   term
);
    import mxm_pkg::*;

    row_pick_e pick_d;

    always_comb begin
        pick_d = decode_pick(xb, yb);
        unique case (pick_d)
            PICK_ZERO: term = '0;
            PICK_XLOW: term = {1'b0, low_x};
            PICK_YLOW: term = {1'b0, low_y};
            PICK_SUM:  term = {sum_msb, sum_low};
            default:   term = '0;
        endcase
    end

endmodule

// File: rtl/mxm_row_accum.sv
module mxm_row_accum #(
    parameter int N           = 8,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic [N-1:0]        op_x,
    input  logic [N-1:0]        op_y,
    input  logic [N-1:0][N:0]   row_terms,
    output logic [2*N-1:0]      product
);
    localparam int PW = 2 * N;

    typedef struct packed {
        logic [PW-1:0] diag;
        logic [PW-1:0] lower;
        logic [PW-1:0] top;
    } accum_t;

    accum_t acc_d;

    always_comb begin
        acc_d.diag  = '0;
        acc_d.lower = '0;
        for (int j = 0; j < N; j++) begin
            acc_d.diag[2*j] = op_x[j] & op_y[j];
        end
        for (int j = 0; j < N - 1; j++) begin
            acc_d.lower = acc_d.lower + ({{(PW-N-1){1'b0}}, row_terms[j]} << j);
        end
        acc_d.top = {{(PW-N-1){1'b0}}, row_terms[N-1]} << (N - 1);
    end

    generate
        if (SIGNED_MODE) begin : g_sub_top
            // inverted top term, carry-in of one
            assign product = acc_d.diag + acc_d.lower + ~acc_d.top + {{(PW-1){1'b0}}, 1'b1};
        end else begin : g_add_top
            assign product = acc_d.diag + acc_d.lower + acc_d.top;
        end
    endgenerate

endmodule

// File: rtl/mux_array_mult.sv
module mux_array_mult #(
    parameter int N            = 8,
    parameter bit SIGNED_MODE  = 1'b0,
    parameter bit MSB_FROM_SUM = 1'b0
) (
    input  logic [N-1:0]   op_x,
    input  logic [N-1:0]   op_y,
    output logic [2*N-1:0] product
);
    logic [N-1:0]      sum_bits;
    logic [N-1:0]      carry_bits;
    logic [N-1:0][N:0] row_terms;

    mxm_operand_adder #(.N(N)) u_adder (
        .add_a      (op_x),
        .add_b      (op_y),
        .sum_bits   (sum_bits),
        .carry_bits (carry_bits)
    );

    assign row_terms[0] = '0;

    generate
        for (genvar j = 1; j < N; j++) begin : g_row
            logic       msb_d;
            logic [j:0] term_d;

            if (MSB_FROM_SUM) begin : g_msb_s
                assign msb_d = sum_bits[j];
            end else begin : g_msb_c
                assign msb_d = carry_bits[j];
            end

            mxm_row_select #(.J(j)) u_sel (
                .xb      (op_x[j]),
                .yb      (op_y[j]),
                .low_x   (op_x[j-1:0]),
                .low_y   (op_y[j-1:0]),
                .sum_low (sum_bits[j-1:0]),
                .sum_msb (msb_d),
                .term    (term_d)
            );

            assign row_terms[j] = {{(N-j){1'b0}}, term_d};
        end
    endgenerate

    mxm_row_accum #(.N(N), .SIGNED_MODE(SIGNED_MODE)) u_accum (
        .op_x      (op_x),
        .op_y      (op_y),
        .row_terms (row_terms),
        .product   (product)
    );

endmodule

// File: rtl/mxm_checker.sv
module mxm_checker #(
    parameter int N           = 8,
    parameter bit SIGNED_MODE = 1'b0
) (
    input logic [N-1:0]      op_x,
    input logic [N-1:0]      op_y,
    input logic [2*N-1:0]    product,
    input logic [N-1:0]      sum_bits,
    input logic [N-1:0]      carry_bits,
    input logic [N-1:0][N:0] row_terms
);
    localparam int PW = 2 * N;

    logic [PW-1:0] ext_x, ext_y, expect_q;
    logic [N:0]    mask, xl, yl;

    always_comb begin
        if (SIGNED_MODE) begin
            ext_x = {{N{op_x[N-1]}}, op_x};
            ext_y = {{N{op_y[N-1]}}, op_y};
        end else begin
            ext_x = {{N{1'b0}}, op_x};
            ext_y = {{N{1'b0}}, op_y};
        end
        expect_q = ext_x * ext_y;

        if (!SIGNED_MODE) begin
            AST_UNSIGNED_PRODUCT: assert (product == expect_q) else $error("unsigned product mismatch"); // R1
        end else begin
            AST_SIGNED_PRODUCT: assert (product == expect_q) else $error("signed product mismatch"); // R2
        end

        if (op_x == '0 || op_y == '0) begin
            AST_ZERO_OPERAND: assert (product == '0) else $error("zero operand gave nonzero"); // R7
        end

        for (int j = 0; j < N; j++) begin
            if (op_x[j] && op_y[j]) begin
                AST_SUM_EQ_CARRY: assert (sum_bits[j] == carry_bits[j]) else $error("sum/carry differ"); // R6
            end
        end

        mask = '0;
        xl   = '0;
        yl   = '0;
        for (int j = 1; j < N; j++) begin
            mask = (({{N{1'b0}}, 1'b1}) << j) - 1'b1;
            xl   = {1'b0, op_x} & mask;
            yl   = {1'b0, op_y} & mask;
            case ({op_x[j], op_y[j]})
                2'b00:   begin AST_ROW_ZERO: assert (row_terms[j] == '0) else $error("row zero"); end // R4
                2'b10:   begin AST_ROW_YLOW: assert (row_terms[j] == yl) else $error("row y"); end // R4
                2'b01:   begin AST_ROW_XLOW: assert (row_terms[j] == xl) else $error("row x"); end // R4
                default: begin AST_ROW_SUM: assert (row_terms[j] == xl + yl) else $error("row sum"); end // R4
            endcase
        end
    end

endmodule

bind mux_array_mult mxm_checker #(.N(N), .SIGNED_MODE(SIGNED_MODE)) u_chk (
    .op_x       (op_x),
    .op_y       (op_y),
    .product    (product),
    .sum_bits   (sum_bits),
    .carry_bits (carry_bits),
    .row_terms  (row_terms)
);

// File: tb/mux_array_mult_test.sv
`timescale 1ns/1ps
module mux_array_mult_test;
    localparam int N  = 8;
    localparam int PW = 2 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]  a_q = '0, b_q = '0;
    logic [PW-1:0] p_uns, p_sgn, p_swap, p_alt;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    mux_array_mult #(.N(N), .SIGNED_MODE(1'b0)) uut (
        .op_x(a_q), .op_y(b_q), .product(p_uns));
    mux_array_mult #(.N(N), .SIGNED_MODE(1'b1)) uut_signed (
        .op_x(a_q), .op_y(b_q), .product(p_sgn));
    mux_array_mult #(.N(N), .SIGNED_MODE(1'b1)) uut_swap (
        .op_x(b_q), .op_y(a_q), .product(p_swap));
    mux_array_mult #(.N(N), .SIGNED_MODE(1'b1), .MSB_FROM_SUM(1'b1)) uut_alt (
        .op_x(a_q), .op_y(b_q), .product(p_alt));

    task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, a_q, b_q, got, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_unsigned(input logic [N-1:0] a, input logic [N-1:0] b);
        int prod;
        prod = int'(a) * int'(b);
        return prod[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] ref_signed(input logic [N-1:0] a, input logic [N-1:0] b);
        int sa, sb, prod;
        sa = int'(a);
        sb = int'(b);
        if (a[N-1]) sa = sa - (1 << N);
        if (b[N-1]) sb = sb - (1 << N);
        prod = sa * sb;
        return prod[PW-1:0];
    endfunction

    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b);
        @(posedge clk);
        a_q = a;
        b_q = b;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset state unsigned", p_uns, '0);
        check("R7 reset state signed", p_sgn, '0);
        rst_n = 1'b1;

        apply(8'hED, 8'h16);
        check("R3 signed -19*22", p_sgn, 16'hFE5E);
        check("R5 swapped -19*22", p_swap, 16'hFE5E);
        apply(8'h80, 8'h7F);
        check("R4 top row picks low y", p_uns, 16'h3F80);
        check("R9 signed min*max", p_sgn, 16'hC080);
        apply(8'hFF, 8'hFF);
        check("R9 unsigned max*max", p_uns, 16'hFE01);
        check("R6 alt slice all ones", p_alt, 16'h0001);
        apply(8'h80, 8'h80);
        check("R9 signed min*min", p_sgn, 16'h4000);
        apply(8'h00, 8'hA5);
        check("R7 zero x", p_uns, '0);
        check("R7 zero x signed", p_sgn, '0);
        apply(8'h3C, 8'h00);
        check("R7 zero y", p_uns, '0);
        // R8: value must appear in the same period the operands change
        apply(8'h0D, 8'h0B);
        check("R8 same-cycle result", p_uns, 16'd143);

        for (int idx = 0; idx < (1 << PW); idx++) begin
            apply(idx[N-1:0], idx[PW-1:N]);
            check("R1 unsigned sweep", p_uns, ref_unsigned(a_q, b_q));
            check("R2 signed sweep", p_sgn, ref_signed(a_q, b_q));
            check("R5 swap sweep", p_swap, p_sgn);
            check("R6 slice variant sweep", p_alt, p_sgn);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R8): actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule